// File: doc/BRIEF.md
# Two-Direction Intersection Signal Sequencer

This block runs the lamps and countdown values of a four-way crossing whose east-west and north-south approaches carry equal traffic. Each approach has its own two-digit BCD down counter. The counters are reloaded separately at every phase boundary. This lets a red side count down its whole wait while the green side counts down its own, so the two displays show different numbers at the same time. A one-second tick enable advances both counters. The phase changes when the counter of the side that is moving reaches 1.

An urgency input freezes the intersection. While it is high, both approaches show red and the phase and both counts hold. When urgency is released, the sequence continues from exactly where it stopped. Seven-segment decoding, digit scanning and the generation of the tick are left to the logic around the block.

Top module: `xing_signal_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the east-west count is 0x45, the north-south count is 0x40 and the lamps are 6'b100_001. This holds whatever the urgency input is doing, but while urgency is high the lamps read all-red.
- R2: Each count output holds two packed BCD digits, tens in bits 7:4 and units in bits 3:0. Each accepted tick lowers the count by one in BCD, so 0x40 is followed by 0x39. A count changes only on a tick.
- R3: The lamp vector is {ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green}. The phases repeat in this order: 100_001, then 100_010, then 001_100, then 010_100.
- R4: In the north-south green phase, the tick that finds the north-south count at 0x01 (the east-west count then reads 0x06) loads 0x05 into both counters and moves to north-south yellow.
- R5: The tick that ends north-south yellow loads 0x40 into the east-west counter and 0x45 into the north-south counter, and east-west turns green.
- R6: The tick that ends east-west yellow loads 0x45 into the east-west counter and 0x40 into the north-south counter, and the block returns to north-south green.
- R7: While urgency is high, the lamps read 6'b100_100, and ticks leave the phase and both counts unchanged.
- R8: After urgency goes low, the phase and counts continue from the values they held when urgency went high.
- R9: Neither count ever shows 0x00. Exactly one lamp per direction is lit at all times.
- R10: One full cycle takes 90 accepted ticks: 40 of north-south green, 5 of north-south yellow, 40 of east-west green and 5 of east-west yellow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| tick | input | 1 | One-second enable, high for one clk cycle |
| urgent | input | 1 | High freezes the sequence and shows red both ways |
| ew_count | output | 8 | East-west countdown, packed BCD |
| ns_count | output | 8 | North-south countdown, packed BCD |
| lamps | output | 6 | {ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green} |

## Verification
The bench runs three full cycles of ticks. Each tick is checked against counts and lamps worked out from the position within the 90-tick cycle, which separates the four reload boundaries from plain BCD decrements, including the borrows from 0x40 to 0x39 and from 0x10 to 0x09. Urgency is raised on a pattern that slips relative to the cycle, so over the run it lands inside every phase and on the boundary ticks themselves. This shows whether a frozen tick is really lost and whether the sequence resumes at the same position. Idle clocks between ticks show whether a count moves without a tick. A reset taken with urgency high shows that reset wins over urgency.

// File: rtl/xing_pkg.sv
package xing_pkg;

  typedef enum logic [1:0] {
    PH_NS_GO   = 2'd0,
    PH_NS_WARN = 2'd1,
    PH_EW_GO   = 2'd2,
    PH_EW_WARN = 2'd3
  } phase_t;

  // lamp order: {ew_r, ew_y, ew_g, ns_r, ns_y, ns_g}
  localparam logic [5:0] LMP_NS_GO   = 6'b100_001;
  localparam logic [5:0] LMP_NS_WARN = 6'b100_010;
  localparam logic [5:0] LMP_EW_GO   = 6'b001_100;
  localparam logic [5:0] LMP_EW_WARN = 6'b010_100;
  localparam logic [5:0] LMP_HALT    = 6'b100_100;

  // binary to packed BCD, up to eight digits
  function automatic logic [31:0] to_bcd(input int unsigned val);
    logic [31:0] r;
    int unsigned v;
    r = '0;
    v = val;
    for (int d = 0; d < 8; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/xing_bcd_down.sv
module xing_bcd_down #(
  parameter int unsigned DIGITS  = 2,
  parameter int unsigned RST_VAL = 45,
  localparam int unsigned CW     = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count
);
  import xing_pkg::*;

  localparam logic [CW-1:0] RST_BCD = CW'(to_bcd(RST_VAL));

  logic [CW-1:0] dec_val;

  always_comb begin
    logic borrow;
    dec_val = count;
    borrow  = 1'b1;
    for (int d = 0; d < int'(DIGITS); d++) begin
      if (borrow) begin
        if (count[4*d +: 4] == 4'd0) begin
          dec_val[4*d +: 4] = 4'd9;
        end else begin
          dec_val[4*d +: 4] = count[4*d +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= RST_BCD;
    end else if (load_en) begin
      count <= load_val;
    end else if (step_en) begin
      count <= dec_val;
    end
  end

endmodule

// File: rtl/xing_phase_seq.sv
module xing_phase_seq #(
  parameter int unsigned DIGITS     = 2,
  parameter int unsigned RED_SEC    = 45,
  parameter int unsigned GREEN_SEC  = 40,
  parameter int unsigned YELLOW_SEC = 5,
  localparam int unsigned CW        = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [CW-1:0]    ew_count,
  input  logic [CW-1:0]    ns_count,
  output xing_pkg::phase_t phase,
  output logic             reload,
  output logic [CW-1:0]    ew_reload,
  output logic [CW-1:0]    ns_reload
);
  import xing_pkg::*;

  localparam logic [CW-1:0] BCD_RED = CW'(to_bcd(RED_SEC));
  localparam logic [CW-1:0] BCD_GRN = CW'(to_bcd(GREEN_SEC));
  localparam logic [CW-1:0] BCD_YEL = CW'(to_bcd(YELLOW_SEC));
  localparam logic [CW-1:0] BCD_END = CW'(1);

  phase_t phase_nxt;
  logic   end_hit;

  // the moving side's counter decides the boundary
  always_comb begin
    unique case (phase)
      PH_NS_GO, PH_NS_WARN: end_hit = (ns_count == BCD_END);
      default:              end_hit = (ew_count == BCD_END);
    endcase
  end

  assign reload = advance & end_hit;

  always_comb begin
    phase_nxt = phase;
    ew_reload = BCD_YEL;
    ns_reload = BCD_YEL;
    unique case (phase)
      PH_NS_GO: begin
        phase_nxt = PH_NS_WARN;
      end
      PH_NS_WARN: begin
        phase_nxt = PH_EW_GO;
        ew_reload = BCD_GRN;
        ns_reload = BCD_RED;
      end
      PH_EW_GO: begin
        phase_nxt = PH_EW_WARN;
      end
      default: begin
        phase_nxt = PH_NS_GO;
        ew_reload = BCD_RED;
        ns_reload = BCD_GRN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_NS_GO;
    end else if (reload) begin
      phase <= phase_nxt;
    end
  end

endmodule

// File: rtl/xing_lamp_map.sv
module xing_lamp_map (
  input  xing_pkg::phase_t phase,
  input  logic             urgent,
  output logic [5:0]       lamps
);
  import xing_pkg::*;

  always_comb begin
    if (urgent) begin
      lamps = LMP_HALT;
    end else begin
      unique case (phase)
        PH_NS_GO:   lamps = LMP_NS_GO;
        PH_NS_WARN: lamps = LMP_NS_WARN;
        PH_EW_GO:   lamps = LMP_EW_GO;
        default:    lamps = LMP_EW_WARN;
      endcase
    end
  end

endmodule

// File: rtl/xing_signal_ctrl.sv
module xing_signal_ctrl #(
  parameter int unsigned DIGITS     = 2,
  parameter int unsigned RED_SEC    = 45,
  parameter int unsigned GREEN_SEC  = 40,
  parameter int unsigned YELLOW_SEC = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                urgent,
  output logic [4*DIGITS-1:0] ew_count,
  output logic [4*DIGITS-1:0] ns_count,
  output logic [5:0]          lamps
);
  import xing_pkg::*;

  localparam int unsigned CW   = 4 * DIGITS;
  localparam int unsigned NDIR = 2;  // index 0 east-west, 1 north-south

  phase_t        phase;
  logic          advance;
  logic          reload;
  logic [CW-1:0] cnt    [NDIR];
  logic [CW-1:0] ld_val [NDIR];

  assign advance = tick & ~urgent;

  xing_phase_seq #(
    .DIGITS    (DIGITS),
    .RED_SEC   (RED_SEC),
    .GREEN_SEC (GREEN_SEC),
    .YELLOW_SEC(YELLOW_SEC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .ew_count (cnt[0]),
    .ns_count (cnt[1]),
    .phase    (phase),
    .reload   (reload),
    .ew_reload(ld_val[0]),
    .ns_reload(ld_val[1])
  );

  for (genvar g = 0; g < int'(NDIR); g++) begin : g_dir
    xing_bcd_down #(
      .DIGITS (DIGITS),
      .RST_VAL((g == 0) ? RED_SEC : GREEN_SEC)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (advance),
      .load_en (reload),
      .load_val(ld_val[g]),
      .count   (cnt[g])
    );
  end

  xing_lamp_map u_lamp (
    .phase (phase),
    .urgent(urgent),
    .lamps (lamps)
  );

  assign ew_count = cnt[0];
  assign ns_count = cnt[1];

endmodule

// File: rtl/xing_signal_chk.sv
module xing_signal_chk #(
  parameter int unsigned DIGITS     = 2,
  parameter int unsigned RED_SEC    = 45,
  parameter int unsigned GREEN_SEC  = 40,
  parameter int unsigned YELLOW_SEC = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                urgent,
  input logic [4*DIGITS-1:0] ew_count,
  input logic [4*DIGITS-1:0] ns_count,
  input logic [5:0]          lamps
);
  import xing_pkg::*;

  localparam int unsigned CW = 4 * DIGITS;
  localparam logic [CW-1:0] C_RED = CW'(to_bcd(RED_SEC));
  localparam logic [CW-1:0] C_GRN = CW'(to_bcd(GREEN_SEC));
  localparam logic [CW-1:0] C_YEL = CW'(to_bcd(YELLOW_SEC));
  localparam logic [CW-1:0] C_ONE = CW'(1);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ew_count) && $stable(ns_count)));

  a_r2_bcd_units: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_count[3:0] <= 4'd9) && (ns_count[3:0] <= 4'd9));

  a_r7_halt_lamps: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> (lamps == LMP_HALT));

  a_r7_halt_counts: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |=> ($stable(ew_count) && $stable(ns_count)));

  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_count != '0) && (ns_count != '0));

  a_r9_one_lamp_each: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lamps[5:3]) == 1) && ($countones(lamps[2:0]) == 1));

  a_r4_ns_to_yellow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !urgent && lamps == LMP_NS_GO && ns_count == C_ONE)
      |=> (ew_count == C_YEL && ns_count == C_YEL));

  a_r5_ew_to_green: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !urgent && lamps == LMP_NS_WARN && ns_count == C_ONE)
      |=> (ew_count == C_GRN && ns_count == C_RED));

  a_r6_back_to_ns: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !urgent && lamps == LMP_EW_WARN && ew_count == C_ONE)
      |=> (ew_count == C_RED && ns_count == C_GRN));

endmodule

bind xing_signal_ctrl xing_signal_chk #(
  .DIGITS    (DIGITS),
  .RED_SEC   (RED_SEC),
  .GREEN_SEC (GREEN_SEC),
  .YELLOW_SEC(YELLOW_SEC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .urgent  (urgent),
  .ew_count(ew_count),
  .ns_count(ns_count),
  .lamps   (lamps)
);

// File: tb/sim_xing_signal_ctrl.sv
`timescale 1ns/1ps
module sim_xing_signal_ctrl;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       urgent;
  logic [7:0] ew_count;
  logic [7:0] ns_count;
  logic [5:0] lamps;

  int n_chk  = 0;
  int n_fail = 0;
  int pos    = 0;   // accepted ticks modulo 90
  bit done   = 0;

  xing_signal_ctrl u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .urgent  (urgent),
    .ew_count(ew_count),
    .ns_count(ns_count),
    .lamps   (lamps)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int exp_ew(input int t);
    if (t < 40) return 45 - t;
    if (t < 45) return 5 - (t - 40);
    if (t < 85) return 40 - (t - 45);
    return 5 - (t - 85);
  endfunction

  function automatic int exp_ns(input int t);
    if (t < 40) return 40 - t;
    if (t < 45) return 5 - (t - 40);
    if (t < 85) return 45 - (t - 45);
    return 5 - (t - 85);
  endfunction

  function automatic logic [5:0] exp_lamp(input int t, input bit urg);
    if (urg)    return 6'b100_100;
    if (t < 40) return 6'b100_001;
    if (t < 45) return 6'b100_010;
    if (t < 85) return 6'b001_100;
    return 6'b010_100;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input int t);
    if (t == 40) return "R4";
    if (t == 45) return "R5";
    if (t == 0)  return "R6";
    if (t == 85) return "R3";
    return "R2";
  endfunction

  task automatic check_state(input string tag, input bit urg);
    check({tag, " ew_count"}, ew_count, bcd(exp_ew(pos)));
    check({tag, " ns_count"}, ns_count, bcd(exp_ns(pos)));
    check({tag, " lamps"}, {2'b00, lamps}, {2'b00, exp_lamp(pos, urg)});
  endtask

  // one tick, then sample on the next falling edge
  task automatic do_tick(input bit urg);
    @(negedge clk);
    tick   = 1'b1;
    urgent = urg;
    @(negedge clk);
    tick = 1'b0;
    if (!urg) pos = (pos + 1) % 90;
    check_state(urg ? "R7" : tag_for(pos), urg);
  endtask

  initial begin
    rst_n  = 1'b0;
    tick   = 1'b0;
    urgent = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 1'b0);

    // one full cycle, plain ticks; R10 at the wrap
    for (int i = 0; i < 90; i++) do_tick(1'b0);
    check("R10 back to start ew", ew_count, 8'h45);
    check("R10 back to start ns", ns_count, 8'h40);

    // idle clocks between ticks must not move the counts
    for (int i = 0; i < 12; i++) begin
      do_tick(1'b0);
      repeat (4) @(negedge clk);
      check_state("R2 idle", 1'b0);
    end

    // urgency on a drifting pattern, two more cycles
    for (int i = 0; i < 200; i++) begin
      bit u;
      u = ((i % 13) == 7) || ((i % 13) == 8) || ((i % 29) == 3);
      do_tick(u);
      if (!u && i > 0) check_state("R8 resume", 1'b0);
      urgent = 1'b0;
    end

    // walk to each boundary and freeze right on it
    for (int b = 0; b < 4; b++) begin
      int target;
      target = (b == 0) ? 39 : (b == 1) ? 44 : (b == 2) ? 84 : 89;
      while (pos != target) do_tick(1'b0);
      do_tick(1'b1);
      do_tick(1'b1);
      urgent = 1'b0;
      do_tick(1'b0);
    end

    // reset while urgency is high
    while (pos != 20) do_tick(1'b0);
    @(negedge clk);
    urgent = 1'b1;
    tick   = 1'b1;
    rst_n  = 1'b0;
    @(negedge clk);
    pos = 0;
    check("R1 reset with urgency ew", ew_count, 8'h45);
    check("R1 reset with urgency ns", ns_count, 8'h40);
    check("R1 reset with urgency lamps", {2'b00, lamps}, 8'b00_100_100);
    tick   = 1'b0;
    urgent = 1'b0;
    @(negedge clk);
    check("R1 reset lamps", {2'b00, lamps}, 8'b00_100_001);
    rst_n = 1'b1;
    do_tick(1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule